// File: doc/BRIEF.md
# Bilateral Weighted Average Core

This core takes a complete square neighbourhood of pixels on every clock and returns one edge-preserving smoothed pixel per clock. Every window position has its own processing element. The element measures how far its pixel lies in intensity from the middle pixel, and uses that distance to look up a weight. The weight falls both with the distance of the position from the middle and with the intensity difference. Each element returns that weight and the weight multiplied by its pixel.

Two registered adder trees collapse the products and the weights. A restoring divider, with one quotient bit per stage, then returns the normalised average. A valid flag travels beside the data through every stage. The total delay is the fixed value `bwa_latency(WIN, PIX_W)` from the package, exported as the top-level localparam `LATENCY` (16 cycles with the defaults), so surrounding logic can line up delayed copies of other data with it. The logic that builds the window from line buffers sits upstream and is not part of this core.

Top module: `bwa_core`

## Requirements
- R1: `win_i` carries WIN×WIN pixels of PIX_W bits. The pixel at row r, column c occupies bits `[(r*WIN+c)*PIX_W +: PIX_W]`, and the middle pixel is at row WIN/2, column WIN/2 (index 40 with the defaults).
- R2: For the pixel at column offset dx and row offset dy from the middle, with absolute intensity difference d to the middle pixel, the weight is `255 >> s` with `s = floor((dx²+dy²)/4) + floor(d/16)`. The weight is 0 when s ≥ 8.
- R3: The output equals floor(Σ pixel·weight / Σ weight) over all window positions. It always lies between the smallest and largest pixel of its window.
- R4: `pix_vld_o` repeats `win_vld_i` exactly 16 cycles later. A new window is accepted on every clock, including back-to-back windows and windows separated by gaps.
- R5: While `rst_n` is low, and afterwards until a valid window has passed through, `pix_vld_o` is 0.
- R6: A window in which every pixel has the same value v produces v.
- R7: The quotient is truncated to PIX_W bits and saturates at 255. A window with every pixel at 255 produces 255, not a wrapped value.
- R8: Pixels that differ from the middle pixel by 128 or more get weight 0 and have no effect. A middle pixel of 20 surrounded by pixels of 200 produces 20.
- R9: The sum of weights is never zero, because the middle position's weight at difference 0 is 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the valid pipeline |
| win_vld_i | input | 1 | Window on `win_i` is valid this cycle |
| win_i | input | WIN*WIN*PIX_W | Flattened pixel window, row-major |
| pix_vld_o | output | 1 | `pix_o` holds a result |
| pix_o | output | PIX_W | Bilateral-smoothed pixel |

## Verification
Each result is due 16 rising edges after the edge that captures its window. The path is 1 stage in the processing elements, 7 adder-tree levels and 8 divider stages. The bench drives a window just after a falling edge and samples `pix_vld_o` and `pix_o` at the sixteenth falling edge after that. In the streaming test, an expected-value stream runs exactly 16 cycles behind the drive stream. The gap test checks that `pix_vld_o` is low in the cycles between results, so a latency that is off by one fails either the value check or the valid check.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

   // Fixed pipeline depth: one PE stage, one per adder-tree level, one per quotient bit.
   function automatic int bwa_latency(input int win, input int qw);
      return 1 + $clog2(win * win) + qw;
   endfunction

   // Spatial part of the weight shift for a window offset.
   function automatic int bwa_spatial_shift(input int dx, input int dy, input int sp_step);
      return (dx * dx + dy * dy) / sp_step;
   endfunction

endpackage

// File: rtl/bwa_pe.sv
module bwa_pe
   import bwa_pkg::*;
#(
   parameter int PIX_W    = 8,
   parameter int WT_W     = 8,
   parameter int DX       = 0,
   parameter int DY       = 0,
   parameter int SP_STEP  = 4,
   parameter int RG_SHIFT = 4
) (
   input  logic                   clk,
   input  logic [PIX_W-1:0]       pix_i,
   input  logic [PIX_W-1:0]       ctr_i,
   output logic [WT_W-1:0]        wt_o,
   output logic [PIX_W+WT_W-1:0]  prod_o
);
   localparam int PROD_W = PIX_W + WT_W;
   localparam int SP_SH  = bwa_spatial_shift(DX, DY, SP_STEP);
   localparam logic [WT_W-1:0] WMAX = '1;

   logic [PIX_W-1:0] diff;
   int unsigned      shamt;
   logic [WT_W-1:0]  wt;

   // Per-position table, evaluated as logic indexed by the difference.
   always_comb begin
      diff  = (pix_i >= ctr_i) ? (pix_i - ctr_i) : (ctr_i - pix_i);
      shamt = SP_SH + 32'(diff >> RG_SHIFT);
      wt    = (shamt >= WT_W) ? '0 : (WMAX >> shamt);
   end

   always_ff @(posedge clk) begin
      wt_o   <= wt;
      prod_o <= PROD_W'(pix_i) * PROD_W'(wt);
   end
endmodule

// File: rtl/bwa_adder_tree.sv
module bwa_adder_tree #(
   parameter int N     = 81,
   parameter int IN_W  = 16,
   parameter int OUT_W = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [N*IN_W-1:0] data_i,
   output logic              vld_o,
   output logic [OUT_W-1:0]  sum_o
);
   localparam int LVL = $clog2(N);
   localparam int P   = 1 << LVL;

   if (N < 2) begin : g_bad_n
      $error("bwa_adder_tree: N must be at least 2");
   end
   if (OUT_W < IN_W + LVL) begin : g_bad_w
      $error("bwa_adder_tree: OUT_W too narrow for N inputs");
   end

   logic [OUT_W-1:0] leaf [P];
   logic [OUT_W-1:0] node [1:P-1];
   logic [LVL-1:0]   vs;

   always_comb begin
      for (int i = 0; i < P; i++) begin
         leaf[i] = (i < N) ? OUT_W'(data_i[i*IN_W +: IN_W]) : '0;
      end
   end

   // Heap layout: every internal node registered, so all leaves see LVL stages.
   for (genvar i = 1; i < P; i++) begin : g_node
      if (2 * i >= P) begin : g_bottom
         always_ff @(posedge clk) node[i] <= leaf[2*i-P] + leaf[2*i+1-P];
      end else begin : g_inner
         always_ff @(posedge clk) node[i] <= node[2*i] + node[2*i+1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vs <= '0;
      end else begin
         vs[0] <= vld_i;
         for (int i = 1; i < LVL; i++) vs[i] <= vs[i-1];
      end
   end

   assign sum_o = node[1];
   assign vld_o = vs[LVL-1];
endmodule

// File: rtl/bwa_divider.sv
module bwa_divider #(
   parameter int NUM_W = 23,
   parameter int DEN_W = 15,
   parameter int Q_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             vld_o,
   output logic [Q_W-1:0]   q_o
);
   localparam int CW = ((NUM_W > DEN_W + Q_W) ? NUM_W : DEN_W + Q_W) + 1;

   if (Q_W < 1) begin : g_bad_q
      $error("bwa_divider: Q_W must be positive");
   end

   logic [CW-1:0]    rem [1:Q_W];
   logic [DEN_W-1:0] den [1:Q_W];
   logic [Q_W-1:0]   q   [1:Q_W];
   logic             sat [1:Q_W];
   logic             vs  [1:Q_W];

   logic [CW-1:0] s0_rem;
   logic          s0_sat;

   always_comb begin
      s0_rem = CW'(num_i);
      s0_sat = s0_rem >= (CW'(den_i) << Q_W);
   end

   for (genvar k = 0; k < Q_W; k++) begin : g_stage
      localparam int B = Q_W - 1 - k;
      logic [CW-1:0]    r_in;
      logic [DEN_W-1:0] d_in;
      logic [Q_W-1:0]   q_in;
      logic             s_in;
      logic             v_in;
      logic [CW-1:0]    cmp;

      if (k == 0) begin : g_first
         assign r_in = s0_rem;
         assign d_in = den_i;
         assign q_in = '0;
         assign s_in = s0_sat;
         assign v_in = vld_i;
      end else begin : g_next
         assign r_in = rem[k];
         assign d_in = den[k];
         assign q_in = q[k];
         assign s_in = sat[k];
         assign v_in = vs[k];
      end

      assign cmp = CW'(d_in) << B;

      always_ff @(posedge clk) begin
         den[k+1] <= d_in;
         sat[k+1] <= s_in;
         if (r_in >= cmp) begin
            rem[k+1] <= r_in - cmp;
            q[k+1]   <= q_in | (Q_W'(1) << B);
         end else begin
            rem[k+1] <= r_in;
            q[k+1]   <= q_in;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) vs[k+1] <= 1'b0;
         else        vs[k+1] <= v_in;
      end
   end

   assign q_o   = sat[Q_W] ? '1 : q[Q_W];
   assign vld_o = vs[Q_W];
endmodule

// File: rtl/bwa_core.sv
module bwa_core
   import bwa_pkg::*;
#(
   parameter int WIN      = 9,
   parameter int PIX_W    = 8,
   parameter int WT_W     = 8,
   parameter int SP_STEP  = 4,
   parameter int RG_SHIFT = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     win_vld_i,
   input  logic [WIN*WIN*PIX_W-1:0] win_i,
   output logic                     pix_vld_o,
   output logic [PIX_W-1:0]         pix_o
);
   localparam int NPE     = WIN * WIN;
   localparam int HALF    = WIN / 2;
   localparam int CTR     = NPE / 2;
   localparam int PROD_W  = PIX_W + WT_W;
   localparam int LVL     = $clog2(NPE);
   localparam int NUM_W   = PROD_W + LVL;
   localparam int DEN_W   = WT_W + LVL;
   localparam int LATENCY = bwa_latency(WIN, PIX_W);

   if (WIN < 3 || (WIN % 2) == 0) begin : g_bad_win
      $error("bwa_core: WIN must be odd and at least 3");
   end
   if (SP_STEP < 1 || RG_SHIFT >= PIX_W) begin : g_bad_shape
      $error("bwa_core: SP_STEP or RG_SHIFT out of range");
   end

   logic [PIX_W-1:0]      ctr_pix;
   logic [NPE*WT_W-1:0]   wts;
   logic [NPE*PROD_W-1:0] prods;
   logic                  pe_vld;
   logic                  num_vld, den_vld;
   logic [NUM_W-1:0]      num_sum;
   logic [DEN_W-1:0]      den_sum;

   assign ctr_pix = win_i[CTR*PIX_W +: PIX_W];

   for (genvar r = 0; r < WIN; r++) begin : g_row
      for (genvar c = 0; c < WIN; c++) begin : g_col
         localparam int K = r * WIN + c;
         bwa_pe #(
            .PIX_W   (PIX_W),
            .WT_W    (WT_W),
            .DX      (c - HALF),
            .DY      (r - HALF),
            .SP_STEP (SP_STEP),
            .RG_SHIFT(RG_SHIFT)
         ) u_pe (
            .clk   (clk),
            .pix_i (win_i[K*PIX_W +: PIX_W]),
            .ctr_i (ctr_pix),
            .wt_o  (wts[K*WT_W +: WT_W]),
            .prod_o(prods[K*PROD_W +: PROD_W])
         );
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pe_vld <= 1'b0;
      else        pe_vld <= win_vld_i;
   end

   bwa_adder_tree #(.N(NPE), .IN_W(PROD_W), .OUT_W(NUM_W)) u_num_tree (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (pe_vld),
      .data_i(prods),
      .vld_o (num_vld),
      .sum_o (num_sum)
   );

   bwa_adder_tree #(.N(NPE), .IN_W(WT_W), .OUT_W(DEN_W)) u_den_tree (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (pe_vld),
      .data_i(wts),
      .vld_o (den_vld),
      .sum_o (den_sum)
   );

   bwa_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W), .Q_W(PIX_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .vld_i(num_vld & den_vld),
      .num_i(num_sum),
      .den_i(den_sum),
      .vld_o(pix_vld_o),
      .q_o  (pix_o)
   );
endmodule

// File: rtl/bwa_core_chk.sv
module bwa_core_chk #(
   parameter int WIN   = 9,
   parameter int PIX_W = 8,
   parameter int DEN_W = 15,
   parameter int LAT   = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     win_vld_i,
   input logic [WIN*WIN*PIX_W-1:0] win_i,
   input logic                     pix_vld_o,
   input logic [PIX_W-1:0]         pix_o,
   input logic                     den_vld,
   input logic [DEN_W-1:0]         den
);
   localparam int NPE = WIN * WIN;

   logic [PIX_W-1:0] mn, mx;
   logic             uni;
   logic [PIX_W-1:0] mnq [LAT];
   logic [PIX_W-1:0] mxq [LAT];
   logic             uq  [LAT];
   logic             vq  [LAT];

   always_comb begin
      mn = '1;
      mx = '0;
      for (int i = 0; i < NPE; i++) begin
         if (win_i[i*PIX_W +: PIX_W] < mn) mn = win_i[i*PIX_W +: PIX_W];
         if (win_i[i*PIX_W +: PIX_W] > mx) mx = win_i[i*PIX_W +: PIX_W];
      end
      uni = (mn == mx);
   end

   always_ff @(posedge clk) begin
      mnq[0] <= mn;
      mxq[0] <= mx;
      uq[0]  <= uni;
      for (int i = 1; i < LAT; i++) begin
         mnq[i] <= mnq[i-1];
         mxq[i] <= mxq[i-1];
         uq[i]  <= uq[i-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LAT; i++) vq[i] <= 1'b0;
      end else begin
         vq[0] <= win_vld_i;
         for (int i = 1; i < LAT; i++) vq[i] <= vq[i-1];
      end
   end

   p_valid_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pix_vld_o == vq[LAT-1]);

   p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pix_vld_o |-> (pix_o >= mnq[LAT-1] && pix_o <= mxq[LAT-1]));

   p_uniform_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_vld_o && uq[LAT-1]) |-> pix_o == mxq[LAT-1]);

   p_den_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      den_vld |-> den != '0);
endmodule

bind bwa_core bwa_core_chk #(
   .WIN  (WIN),
   .PIX_W(PIX_W),
   .DEN_W(DEN_W),
   .LAT  (LATENCY)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .win_vld_i(win_vld_i),
   .win_i    (win_i),
   .pix_vld_o(pix_vld_o),
   .pix_o    (pix_o),
   .den_vld  (den_vld),
   .den      (den_sum)
);

// File: tb/bwa_core_bench.sv
module bwa_core_bench;
   localparam int WIN = 9;
   localparam int NPE = WIN * WIN;
   localparam int NB  = NPE * 8;
   localparam int LAT = 16;
   localparam int CTR = 40;
   localparam int NSTREAM = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          win_vld_i = 1'b0;
   logic [NB-1:0] win_i = '0;
   logic          pix_vld_o;
   logic [7:0]    pix_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   bwa_core u_bwa_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .win_vld_i(win_vld_i),
      .win_i    (win_i),
      .pix_vld_o(pix_vld_o),
      .pix_o    (pix_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Reference from R2/R3/R7
   function automatic int ref_pix(input logic [NB-1:0] w);
      int ctr, num, den, p, d, s, wt, q;
      ctr = int'(w[CTR*8 +: 8]);
      num = 0;
      den = 0;
      for (int r = 0; r < WIN; r++) begin
         for (int c = 0; c < WIN; c++) begin
            p  = int'(w[(r*WIN+c)*8 +: 8]);
            d  = (p > ctr) ? p - ctr : ctr - p;
            s  = ((c-4)*(c-4) + (r-4)*(r-4)) / 4 + d / 16;
            wt = (s >= 8) ? 0 : (255 >> s);
            num += p * wt;
            den += wt;
         end
      end
      q = num / den;
      return (q > 255) ? 255 : q;
   endfunction

   function automatic logic [NB-1:0] fill(input int v);
      logic [NB-1:0] w;
      for (int k = 0; k < NPE; k++) w[k*8 +: 8] = 8'(v);
      return w;
   endfunction

   task automatic run_one(input logic [NB-1:0] w, input string req);
      win_i     = w;
      win_vld_i = 1'b1;
      @(negedge clk);
      win_vld_i = 1'b0;
      repeat (LAT - 1) @(negedge clk);
      check({req, " valid"}, int'(pix_vld_o), 1);
      check({req, " value"}, int'(pix_o), ref_pix(w));
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R5 during reset", int'(pix_vld_o), 0);
      rst_n = 1'b1;
      repeat (LAT + 2) @(negedge clk);
      check("R5 idle after reset", int'(pix_vld_o), 0);
   endtask

   task automatic t_uniform();
      run_one(fill(0), "R6 uniform 0");
      run_one(fill(77), "R6 uniform 77");
      run_one(fill(255), "R7 full scale 255");
      check("R7 no wrap", int'(pix_o), 255);
   endtask

   task automatic t_single();
      logic [NB-1:0] w;
      w = fill(0);
      w[(4*WIN+5)*8 +: 8] = 8'd100;
      run_one(w, "R2 R1 offset (1,0)");
      w = fill(0);
      w[(2*WIN+3)*8 +: 8] = 8'd40;
      run_one(w, "R2 R1 offset (-1,-2)");
      w = fill(0);
      w[(0*WIN+8)*8 +: 8] = 8'd10;
      run_one(w, "R2 corner");
   endtask

   task automatic t_edge();
      logic [NB-1:0] w;
      w = fill(200);
      w[CTR*8 +: 8] = 8'd20;
      run_one(w, "R8 isolated middle");
      check("R8 R9 middle only", int'(pix_o), 20);
      w = fill(20);
      for (int r = 0; r < WIN; r++)
         for (int c = 0; c < 4; c++) w[(r*WIN+c)*8 +: 8] = 8'd230;
      run_one(w, "R8 step edge");
      check("R8 edge kept", int'(pix_o), 20);
   endtask

   task automatic t_stream();
      logic [NB-1:0] ws [NSTREAM];
      for (int j = 0; j < NSTREAM; j++) begin
         int base;
         base = int'($urandom_range(0, 255));
         for (int k = 0; k < NPE; k++) begin
            if (j % 2 == 0) ws[j][k*8 +: 8] = 8'($urandom_range(0, 255));
            else ws[j][k*8 +: 8] = 8'((base + int'($urandom_range(0, 40))) % 256);
         end
      end
      fork
         begin
            for (int j = 0; j < NSTREAM; j++) begin
               win_i     = ws[j];
               win_vld_i = 1'b1;
               @(negedge clk);
            end
            win_vld_i = 1'b0;
         end
         begin
            repeat (LAT) @(negedge clk);
            for (int j = 0; j < NSTREAM; j++) begin
               check("R4 stream valid", int'(pix_vld_o), 1);
               check("R3 stream value", int'(pix_o), ref_pix(ws[j]));
               @(negedge clk);
            end
            check("R4 stream end", int'(pix_vld_o), 0);
         end
      join
   endtask

   task automatic t_gaps();
      logic [NB-1:0] a, b;
      a = fill(50);
      b = fill(0);
      b[CTR*8 +: 8] = 8'd60;
      fork
         begin
            win_i = a; win_vld_i = 1'b1; @(negedge clk);
            win_vld_i = 1'b0;            @(negedge clk);
            @(negedge clk);
            win_i = b; win_vld_i = 1'b1; @(negedge clk);
            win_vld_i = 1'b0;
         end
         begin
            repeat (LAT - 1) @(negedge clk);
            check("R4 before first", int'(pix_vld_o), 0);
            @(negedge clk);
            check("R4 first", int'(pix_vld_o), 1);
            check("R4 first value", int'(pix_o), 50);
            @(negedge clk);
            check("R4 gap 1", int'(pix_vld_o), 0);
            @(negedge clk);
            check("R4 gap 2", int'(pix_vld_o), 0);
            @(negedge clk);
            check("R4 second", int'(pix_vld_o), 1);
            check("R3 second value", int'(pix_o), ref_pix(b));
         end
      join
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_uniform();
      t_single();
      t_edge();
      t_stream();
      t_gaps();
      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule